// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block collects a parameterised set of external interrupt lines and steers each one to a single (core, pin) destination. For every source it keeps a pending level, an enable bit, a destination pin field with a mapping flag, and a destination core. Every (core, pin) pair has its own output. That output is high when at least one source mapped to the pair is both pending and enabled, or when the matching external local term is high.

Software reaches the state through a simple word-wide register port with byte addresses and one cycle of read latency. The pending and enable state reads back as bitmaps. Enables change only through separate set and clear registers. Each source has a pin map word and a core map word. The core map is written as a one-hot vector and read back the same way. A trigger register lets software force the pending level of any source. A read-only configuration word reports the size of the block.

Top module: `shared_irq_router`

## Requirements
- R1: After synchronous reset, every source is disabled and not pending, its core map reads 0, its pin map reads 0x8000_0000 (flag set, pin 0), and all outputs are low.
- R2: A source's pending bit takes the new input level one cycle after the input changes, whether or not the source is enabled. The pending bitmap sits at 0x020: bit i of the word at 0x020+4w is source 32w+i.
- R3: The enable bitmap sits at 0x040 with the same layout. A write to the set register at 0x080+4w enables source 32w+i for each data bit i that is 1. Zero bits change nothing.
- R4: A write to the clear register at 0x060+4w disables source 32w+i for each data bit i that is 1. Zero bits change nothing.
- R5: Output bit c*NUM_PIN+p is the registered OR, one cycle after the state, of pending AND enabled over every source whose stored core is c and whose stored pin is p.
- R6: A disabled source never drives an output, even while it is pending.
- R7: The pin map of source s is at 0x400+4s, with bit 31 as the mapping flag and bits 5:0 as the pin. A write whose pin field is greater than NUM_PIN-1 is ignored.
- R8: The core map of source s is at 0x2000+32s. A write stores the index of the lowest set data bit. A write of zero unmaps the source, and an unmapped source drives nothing. A write whose lowest set bit is NUM_CORE or more is ignored. A read returns a one-hot vector of the stored index, or 0 when the source is unmapped.
- R9: A write to the trigger register at 0x004 sets the pending bit of the source named by bits 30:0 to the value of bit 31. A write naming an index of NUM_SRC or more changes nothing.
- R10: The word at 0x000 reads NUM_SRC/8-1 in bits 15:0 and NUM_CORE in bits 23:16. Writes to it change nothing.
- R11: Each bit of ext_local is ORed into the same-numbered output, with the same one-cycle register delay.
- R12: Read data appears on bus_rdata one cycle after the read. Map registers of sources at or above NUM_SRC, and bitmap bits above NUM_SRC-1, read 0 and ignore writes. Accesses whose two low address bits are not zero are ignored and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | External interrupt levels |
| ext_local | input | NUM_CORE*NUM_PIN | Local pending terms ORed into the outputs |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| irq_out | output | NUM_CORE*NUM_PIN | Per (core, pin) interrupt, index core*NUM_PIN+pin |

## Verification
The bench builds the block with 40 sources. This places the second bitmap word and the upper map addresses partly out of range. A decoder that ignored the range would return stale or aliased data there. The bench raises a source while it is disabled and checks that the pending bit shows it but no output does. An enable that gated the pending latch would hide the bit, and one that gated nothing would leak an interrupt. The bench writes core vectors whose lowest set bit is out of range, writes with several bits set, and writes zero. A design that took the highest bit, or stored the out-of-range index, would move the interrupt to the wrong output. The bench also writes trigger indices past the end, pin fields past the top pin, and misaligned addresses, and requires that each of these leaves the state untouched.

// File: rtl/sir_pkg.sv
`timescale 1ns/1ps
package sir_pkg;
  localparam int ADDR_W  = 14;
  localparam int DATA_W  = 32;
  localparam int PIN_FW  = 6;
  localparam int MAX_SRC = 256;

  typedef enum logic [3:0] {
    RG_NONE, RG_CFG, RG_TRIG, RG_PEND, RG_ENRD, RG_CLR, RG_SET, RG_PIN, RG_CORE
  } region_e;

  function automatic logic [4:0] lowest_set(input logic [DATA_W-1:0] v);
    logic [4:0] r;
    r = 5'd0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/sir_decode.sv
`timescale 1ns/1ps
module sir_decode
  import sir_pkg::*;
#(
  parameter int NUM_SRC = 256
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rgn,
  output logic [2:0]        word,
  output logic [7:0]        src,
  output logic              src_ok
);
  always_comb begin
    rgn  = RG_NONE;
    src  = 8'd0;
    word = addr[4:2];
    if (addr[1:0] == 2'b00) begin
      if (addr[13]) begin
        rgn = RG_CORE;
        src = addr[12:5];
      end else if (addr[13:10] == 4'b0001) begin
        rgn = RG_PIN;
        src = addr[9:2];
      end else if (addr[13:8] == 6'd0) begin
        case (addr[7:5])
          3'd0: begin
            if (addr[4:2] == 3'd0)      rgn = RG_CFG;
            else if (addr[4:2] == 3'd1) rgn = RG_TRIG;
          end
          3'd1: rgn = RG_PEND;
          3'd2: rgn = RG_ENRD;
          3'd3: rgn = RG_CLR;
          3'd4: rgn = RG_SET;
          default: rgn = RG_NONE;
        endcase
      end
    end
    src_ok = (32'(src) < 32'(NUM_SRC));
  end
endmodule

// File: rtl/sir_src_state.sv
`timescale 1ns/1ps
module sir_src_state
  import sir_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 6,
  localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic                wr_set,
  input  logic                wr_clr,
  input  logic                wr_trig,
  input  logic                wr_pin,
  input  logic                wr_core,
  input  logic [2:0]          word,
  input  logic [7:0]          src,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_SRC-1:0]  pend,
  output logic [NUM_SRC-1:0]  en,
  output logic [NUM_SRC-1:0]  pin_flag,
  output logic [PIN_FW-1:0]   pin_num [NUM_SRC],
  output logic [NUM_SRC-1:0]  core_ok,
  output logic [CORE_W-1:0]   core_idx [NUM_SRC]
);
  logic [NUM_SRC-1:0] in_q;
  logic [4:0]         lo;
  logic               core_zero, core_fit, pin_fit;

  assign lo        = lowest_set(wdata);
  assign core_zero = (wdata == '0);
  assign core_fit  = ({27'd0, lo} < 32'(NUM_CORE));
  assign pin_fit   = ({26'd0, wdata[PIN_FW-1:0]} < 32'(NUM_PIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q     <= '0;
      pend     <= '0;
      en       <= '0;
      pin_flag <= '1;
      core_ok  <= '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        pin_num[s]  <= '0;
        core_idx[s] <= '0;
      end
    end else begin
      in_q <= irq_in;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (wr_trig && wdata[30:0] == 31'(s))
          pend[s] <= wdata[31];
        else if (irq_in[s] != in_q[s])
          pend[s] <= irq_in[s];

        if (wr_set && word == 3'(s / 32) && wdata[5'(s % 32)])
          en[s] <= 1'b1;
        else if (wr_clr && word == 3'(s / 32) && wdata[5'(s % 32)])
          en[s] <= 1'b0;

        if (wr_pin && src == 8'(s) && pin_fit) begin
          pin_flag[s] <= wdata[31];
          pin_num[s]  <= wdata[PIN_FW-1:0];
        end

        if (wr_core && src == 8'(s)) begin
          if (core_zero) begin
            core_ok[s] <= 1'b0;
          end else if (core_fit) begin
            core_ok[s]  <= 1'b1;
            core_idx[s] <= lo[CORE_W-1:0];
          end
        end
      end
    end
  end

  assert_trig_range_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_trig && {1'b0, wdata[30:0]} >= 32'(NUM_SRC) && irq_in == in_q) |=> $stable(pend));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    assert_pend_follow_R2: assert property (@(posedge clk) disable iff (rst)
      ((irq_in[s] != in_q[s]) && !(wr_trig && wdata[30:0] == 31'(s)))
        |=> pend[s] == $past(irq_in[s]));
    assert_clear_hits_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_clr && word == 3'(s / 32) && wdata[s % 32]) |=> !en[s]);
    assert_pin_guard_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_pin && !pin_fit) |=> $stable(pin_num[s]) && $stable(pin_flag[s]));
    assert_core_guard_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_core && !core_zero && !core_fit) |=> $stable(core_ok[s]) && $stable(core_idx[s]));
  end
endmodule

// File: rtl/sir_fanin.sv
`timescale 1ns/1ps
module sir_fanin
  import sir_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 6,
  localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
  localparam int NOUT    = NUM_CORE * NUM_PIN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  input  logic [PIN_FW-1:0]  pin_num [NUM_SRC],
  input  logic [NUM_SRC-1:0] core_ok,
  input  logic [CORE_W-1:0]  core_idx [NUM_SRC],
  input  logic [NOUT-1:0]    ext_local,
  output logic [NOUT-1:0]    irq_out
);
  logic [NUM_SRC-1:0] live;
  logic [NOUT-1:0]    route_d;

  assign live = pend & en & core_ok;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic [NUM_SRC-1:0] hit;
      always_comb begin
        for (int s = 0; s < NUM_SRC; s++)
          hit[s] = live[s] && (core_idx[s] == CORE_W'(c)) && (pin_num[s] == PIN_FW'(p));
      end
      assign route_d[c*NUM_PIN + p] = (|hit) | ext_local[c*NUM_PIN + p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= route_d;
  end

  assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (((pend & en) == '0) && ext_local == '0) |=> irq_out == '0);
endmodule

// File: rtl/shared_irq_router.sv
`timescale 1ns/1ps
module shared_irq_router
  import sir_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 6,
  localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int NOUT    = NUM_CORE * NUM_PIN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NOUT-1:0]    ext_local,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [13:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NOUT-1:0]    irq_out
);
  localparam logic [31:0] CFG_WORD = {8'h00, 8'(NUM_CORE), 16'(NUM_SRC / 8 - 1)};

  region_e            rgn;
  logic [2:0]         word;
  logic [7:0]         src;
  logic               src_ok, wr, rd;
  logic [NUM_SRC-1:0] pend, en, pin_flag, core_ok;
  logic [PIN_FW-1:0]  pin_num  [NUM_SRC];
  logic [CORE_W-1:0]  core_idx [NUM_SRC];
  logic [MAX_SRC-1:0] pend_pad, en_pad;
  logic [SRC_W-1:0]   src_i;
  logic [31:0]        rd_d;

  sir_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .addr(bus_addr), .rgn(rgn), .word(word), .src(src), .src_ok(src_ok)
  );

  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;

  sir_src_state #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_state (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .wr_set (wr && rgn == RG_SET),
    .wr_clr (wr && rgn == RG_CLR),
    .wr_trig(wr && rgn == RG_TRIG),
    .wr_pin (wr && rgn == RG_PIN  && src_ok),
    .wr_core(wr && rgn == RG_CORE && src_ok),
    .word(word), .src(src), .wdata(bus_wdata),
    .pend(pend), .en(en), .pin_flag(pin_flag), .pin_num(pin_num),
    .core_ok(core_ok), .core_idx(core_idx)
  );

  sir_fanin #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_fan (
    .clk(clk), .rst(rst), .pend(pend), .en(en), .pin_num(pin_num),
    .core_ok(core_ok), .core_idx(core_idx), .ext_local(ext_local), .irq_out(irq_out)
  );

  assign pend_pad = MAX_SRC'(pend);
  assign en_pad   = MAX_SRC'(en);
  assign src_i    = src[SRC_W-1:0];

  always_comb begin
    rd_d = '0;
    case (rgn)
      RG_CFG:  rd_d = CFG_WORD;
      RG_PEND: rd_d = pend_pad[{word, 5'd0} +: 32];
      RG_ENRD: rd_d = en_pad[{word, 5'd0} +: 32];
      RG_PIN:  if (src_ok) rd_d = {pin_flag[src_i], 25'd0, pin_num[src_i]};
      RG_CORE: if (src_ok && core_ok[src_i]) rd_d = 32'd1 << core_idx[src_i];
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_d;
  end

  assert_far_src_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (rd && (rgn == RG_PIN || rgn == RG_CORE) && !src_ok) |=> bus_rdata == '0);
  assert_core_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rd) && $past(rgn) == RG_CORE) |-> $onehot0(bus_rdata));
endmodule

// File: tb/sim_shared_irq_router.sv
`timescale 1ns/1ps
module sim_shared_irq_router;
  localparam int NS   = 40;
  localparam int NC   = 4;
  localparam int NP   = 6;
  localparam int NOUT = NC * NP;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS-1:0]   irq_in = '0;
  logic [NOUT-1:0] ext_local = '0;
  logic            bus_en = 1'b0, bus_we = 1'b0;
  logic [13:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NOUT-1:0] irq_out;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  shared_irq_router #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(NP)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .ext_local(ext_local),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // behavioural reference state
  bit m_pend[NS], m_en[NS], m_flag[NS], m_cok[NS], m_inq[NS];
  int m_pin[NS], m_core[NS];
  logic [NOUT-1:0] exp_out;
  logic [31:0]     m_rd;

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] r = '0;
    int s;
    if ((a & 3) != 0) return '0;
    if (a == 0) r = {8'h00, 8'(NC), 16'(NS / 8 - 1)};
    else if (a >= 'h20 && a < 'h60) begin
      for (int i = 0; i < 32; i++) begin
        s = ((a & 'h1f) / 4) * 32 + i;
        if (s < NS) r[i] = (a < 'h40) ? m_pend[s] : m_en[s];
      end
    end else if (a >= 'h400 && a < 'h800) begin
      s = (a - 'h400) / 4;
      if (s < NS) r = {m_flag[s], 25'd0, 6'(m_pin[s])};
    end else if (a >= 'h2000 && a < 'h4000) begin
      s = (a - 'h2000) / 32;
      if (s < NS && m_cok[s]) r = 32'd1 << m_core[s];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    int a, s, lo, trig;
    logic [NOUT-1:0] nxt;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        m_pend[i] = 0; m_en[i] = 0; m_flag[i] = 1; m_cok[i] = 0;
        m_inq[i] = 0; m_pin[i] = 0; m_core[i] = 0;
      end
      exp_out = '0;
      m_rd = '0;
    end else begin
      nxt = ext_local;
      for (int i = 0; i < NS; i++)
        if (m_pend[i] && m_en[i] && m_cok[i]) nxt[m_core[i] * NP + m_pin[i]] = 1'b1;
      a = int'(bus_addr);
      trig = -1;
      if (bus_en && !bus_we) m_rd = model_read(a);
      if (bus_en && bus_we && (a & 3) == 0) begin
        if (a == 4) begin
          trig = int'(bus_wdata[30:0]);
          if (trig < NS) m_pend[trig] = bus_wdata[31];
        end else if (a >= 'h60 && a < 'ha0) begin
          for (int i = 0; i < 32; i++) begin
            s = ((a & 'h1f) / 4) * 32 + i;
            if (s < NS && bus_wdata[i]) m_en[s] = (a >= 'h80);
          end
        end else if (a >= 'h400 && a < 'h800) begin
          s = (a - 'h400) / 4;
          if (s < NS && int'(bus_wdata[5:0]) < NP) begin
            m_flag[s] = bus_wdata[31]; m_pin[s] = int'(bus_wdata[5:0]);
          end
        end else if (a >= 'h2000 && a < 'h4000) begin
          s = (a - 'h2000) / 32;
          if (s < NS) begin
            if (bus_wdata == 0) m_cok[s] = 0;
            else begin
              lo = 0;
              while (!bus_wdata[lo]) lo++;
              if (lo < NC) begin m_cok[s] = 1; m_core[s] = lo; end
            end
          end
        end
      end
      for (int i = 0; i < NS; i++) begin
        if (i != trig && irq_in[i] != m_inq[i]) m_pend[i] = irq_in[i];
        m_inq[i] = irq_in[i];
      end
      exp_out = nxt;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // R5: every output compared with the reference on every clock
  always @(negedge clk) begin
    if (!rst) chk(irq_out == exp_out, "R5 per-cycle outputs", 32'(irq_out), 32'(exp_out));
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 14'(a); bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = 14'(a);
    @(negedge clk); bus_en = 0;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
    chk(bus_rdata == m_rd, {tag, " (model)"}, bus_rdata, m_rd);
  endtask

  task automatic ochk(input int k, input bit exp, input string tag);
    chk(irq_out[k] == exp, tag, 32'(irq_out[k]), 32'(exp));
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    chk(irq_out == '0, "R1 outputs after reset", 32'(irq_out), 0);
    rd('h040, 0, "R1 enables clear");
    rd('h020, 0, "R1 nothing pending");
    rd('h40C, 32'h8000_0000, "R1 pin map reset");
    rd('h2060, 0, "R1 core unmapped");
    rd('h000, 32'h0004_0004, "R10 config word");

    // map source 5 to core 2, pin 2 (output 14)
    wr('h414, 32'd2);
    wr('h20A0, 32'h4);
    rd('h414, 32'd2, "R7 pin readback");
    rd('h20A0, 32'h4, "R8 core one-hot readback");

    // R2 / R6: pending while disabled
    @(negedge clk); irq_in[5] = 1;
    idle(2);
    rd('h020, 32'h20, "R2 pending while disabled");
    ochk(14, 0, "R6 disabled source silent");

    // R3 enable via set register
    wr('h080, 32'h20);
    idle(1);
    ochk(14, 1, "R5 enabled source drives its pair");
    rd('h040, 32'h20, "R3 enable bitmap");
    wr('h080, 32'h0);
    rd('h040, 32'h20, "R3 zero bits no effect");

    // second source 35 on same pair, raised by trigger
    wr('h48C, 32'd2);
    wr('h2460, 32'h4);
    wr('h084, 32'h8);
    wr('h004, 32'h8000_0023);
    rd('h024, 32'h8, "R9 trigger sets pending, R2 word layout");
    @(negedge clk); irq_in[5] = 0;
    idle(2);
    ochk(14, 1, "R5 OR of two sources");
    wr('h060, 32'h0);
    rd('h040, 32'h20, "R4 zero bits no effect");
    wr('h064, 32'h8);
    idle(1);
    ochk(14, 0, "R4 cleared source silent");
    rd('h044, 0, "R4 enable cleared");

    // R7 pin guard
    wr('h414, 32'd6);
    rd('h414, 32'd2, "R7 out-of-range pin ignored");
    wr('h414, 32'h8000_0005);
    rd('h414, 32'h8000_0005, "R7 flag and pin stored");

    // R8 core map
    @(negedge clk); irq_in[5] = 1;
    idle(2);
    ochk(17, 1, "R5 core2 pin5");
    wr('h20A0, 32'h80);
    rd('h20A0, 32'h4, "R8 out-of-range core ignored");
    wr('h20A0, 32'hA);
    rd('h20A0, 32'h2, "R8 lowest set bit kept");
    idle(1);
    ochk(11, 1, "R8 moved to core1");
    ochk(17, 0, "R8 old pair released");
    wr('h20A0, 32'h0);
    rd('h20A0, 32'h0, "R8 unmapped reads zero");
    idle(1);
    ochk(11, 0, "R8 unmapped source silent");

    // R9 trigger range and clear
    wr('h004, 32'h8000_0028);
    rd('h024, 32'h8, "R9 out-of-range trigger ignored");
    wr('h004, 32'h0000_0023);
    rd('h024, 32'h0, "R9 trigger clears pending");

    // R11 external local term
    @(negedge clk); ext_local[7] = 1;
    idle(2);
    ochk(7, 1, "R11 local term reaches output");
    @(negedge clk); ext_local[7] = 0;
    idle(2);
    ochk(7, 0, "R11 local term released");

    // R12 out-of-range and misaligned accesses, R10 read-only
    rd('h4B4, 0, "R12 pin map beyond sources");
    wr('h4B4, 32'd3);
    rd('h4B4, 0, "R12 write beyond sources ignored");
    rd('h25A0, 0, "R12 core map beyond sources");
    rd('h048, 0, "R12 bitmap beyond sources");
    wr('h416, 32'd1);
    rd('h414, 32'h8000_0005, "R12 misaligned write ignored");
    wr('h000, 32'hFFFF_FFFF);
    rd('h000, 32'h0004_0004, "R10 config read-only");

    idle(3);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule